// File: doc/BRIEF.md
# Printer Port Register Emulator

This block presents the three byte-wide registers of a classic printer port to a host bus and plays the part of a simple printer attached behind them. The host writes a byte into the data register, then toggles the strobe bit of the control register. On the strobe the block pushes the byte out on an output byte stream and drops the busy flag. As the host keeps polling the status register, each poll moves the acknowledge and busy flags one step through the usual handshake. If the host enabled interrupts in the control register, a strobe release raises an interrupt that stays high until the next status read.

A separate input lets the surrounding logic load the byte that the printer side would drive back, so that reads in the input direction return it. The output stream follows valid/ready rules. A byte stays on `tx_data` with `tx_valid` high until the cycle in which `tx_ready` is also high. Up to `OUT_DEPTH` bytes wait in order behind it. A byte strobed while that store is full and not draining is dropped. Read data is registered and appears in the cycle after the read request.

Top module: `prt_port_regs`

## Requirements
- R1: Offset 0 (of the 3-bit address) is data, 1 is status and 2 is control. A read of offsets 3 to 7 returns 0xFF. Writes to offset 1 or to offsets 3 to 7 change no register. Read data appears on `bus_rdata` one cycle after the read and holds until the next read.
- R2: After reset, a control read returns 0xCC, a status read returns 0xD9 and a data read returns 0xFF, with `irq` and `tx_valid` low.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and a later control read returns that value.
- R4: A control write with bit 2 (init) at 0 sets status to 0xD8.
- R5: A control write with bit 2 and bit 3 (select) at 1 and bit 0 (strobe) at 1 clears status bit 7 (busy, inverted sense). It emits the data register byte on the stream only when the previously stored strobe bit was 0.
- R6: A control write with bit 2 and bit 3 at 1 and bit 0 at 0 sets the interrupt pending flag when the previously stored control value had bit 4 (interrupt enable) set. `irq` follows that flag from the next cycle.
- R7: A status read returns the status held before the read and clears the pending flag, so `irq` is low in the following cycle.
- R8: A status read that finds status bit 7 at 0 and control bit 0 at 0 advances the handshake. If status bit 6 (acknowledge) is 1 it is cleared; otherwise bits 6 and 7 are both set.
- R9: A data read returns the last byte taken from the peripheral input when control bit 5 (direction) is 1, and the last byte written by the host otherwise.
- R10: A cycle with `pin_valid` high loads `pin_data` as the peripheral input byte.
- R11: Emitted bytes leave in strobe order. `tx_data` holds steady while `tx_valid` is high and `tx_ready` low. At most `OUT_DEPTH` bytes are held, and a byte strobed while full and not draining is dropped.
- R12: When `bus_rd_en` and `bus_wr_en` are high in the same cycle, the write takes effect and the read is ignored, leaving `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Host write request |
| bus_rd_en | input | 1 | Host read request |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| pin_valid | input | 1 | Load the peripheral input byte |
| pin_data | input | 8 | Peripheral input byte |
| tx_valid | output | 1 | Emitted byte available |
| tx_ready | input | 1 | Sink accepts the emitted byte |
| tx_data | output | 8 | Emitted byte |
| irq | output | 1 | Interrupt, high while pending |

## Verification
The bench builds the block with `OUT_DEPTH` set to 2 instead of the default 4. This way three strobes against a stalled sink are enough to fill the output store and reach the drop case. The same stall shows that the head byte holds steady and that the surviving bytes drain in order once the sink resumes. The other scenarios each start from reset. They walk the acknowledge/busy sequence poll by poll, and they separate a repeated strobe from a fresh strobe edge.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int unsigned ST_BUSY_N = 7;
  localparam int unsigned ST_ACK    = 6;
  // control bit positions
  localparam int unsigned CT_DIR  = 5;
  localparam int unsigned CT_IEN  = 4;
  localparam int unsigned CT_SEL  = 3;
  localparam int unsigned CT_INIT = 2;
  localparam int unsigned CT_STB  = 0;

  localparam logic [BYTE_W-1:0] RST_STAT   = 8'hD9;
  localparam logic [BYTE_W-1:0] INIT_STAT  = 8'hD8;
  localparam logic [BYTE_W-1:0] RST_CTRL   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] RD_FILL    = 8'hFF;
endpackage

// File: rtl/prt_reg_core.sv
module prt_reg_core
  import prt_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              pin_valid,
  input  logic [W-1:0]      pin_data,
  output logic [W-1:0]      dataw_q,
  output logic [W-1:0]      datar_q,
  output logic [W-1:0]      stat_q,
  output logic [W-1:0]      ctrl_q,
  output logic              pend_q,
  output logic              emit,
  output logic [W-1:0]      emit_data
);
  logic [W-1:0] dataw_d, stat_d, ctrl_d, ctrl_new;
  logic         pend_d;
  logic         stat_rd;

  // a write wins over a read in the same cycle
  assign stat_rd   = rd_en && !wr_en && (addr == OFF_STAT);
  assign emit_data = dataw_q;

  always_comb begin
    dataw_d  = dataw_q;
    stat_d   = stat_q;
    ctrl_d   = ctrl_q;
    pend_d   = pend_q;
    emit     = 1'b0;
    ctrl_new = wdata | W'(CTRL_FORCE);
    if (wr_en) begin
      case (addr)
        OFF_DATA: dataw_d = wdata;
        OFF_CTRL: begin
          if (!ctrl_new[CT_INIT]) begin
            stat_d = W'(INIT_STAT);
          end else if (ctrl_new[CT_SEL]) begin
            if (ctrl_new[CT_STB]) begin
              stat_d[ST_BUSY_N] = 1'b0;
              if (!ctrl_q[CT_STB]) emit = 1'b1;
            end else if (ctrl_q[CT_IEN]) begin
              pend_d = 1'b1;
            end
          end
          // stored only after the edge tests used the old value
          ctrl_d = ctrl_new;
        end
        default: ;
      endcase
    end else if (stat_rd) begin
      pend_d = 1'b0;
      if (!stat_q[ST_BUSY_N] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_d[ST_ACK] = 1'b0;
        end else begin
          stat_d[ST_ACK]    = 1'b1;
          stat_d[ST_BUSY_N] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataw_q <= '1;
      stat_q  <= W'(RST_STAT);
      ctrl_q  <= W'(RST_CTRL);
      pend_q  <= 1'b0;
    end else begin
      dataw_q <= dataw_d;
      stat_q  <= stat_d;
      ctrl_q  <= ctrl_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         datar_q <= '1;
    else if (pin_valid) datar_q <= pin_data;
  end
endmodule

// File: rtl/prt_rd_mux.sv
module prt_rd_mux
  import prt_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      dataw,
  input  logic [W-1:0]      datar,
  input  logic [W-1:0]      stat,
  input  logic [W-1:0]      ctrl,
  output logic [W-1:0]      rdata_q
);
  logic [W-1:0] sel;

  always_comb begin
    case (addr)
      OFF_DATA: sel = ctrl[CT_DIR] ? datar : dataw;
      OFF_STAT: sel = stat;
      OFF_CTRL: sel = ctrl;
      default:  sel = W'(RD_FILL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rdata_q <= W'(RD_FILL);
    else if (rd_en && !wr_en)  rdata_q <= sel;
  end
endmodule

// File: rtl/prt_byte_fifo.sv
module prt_byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, pop, accept;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt == CNT_W'(DEPTH));
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && out_ready;
  assign accept    = push && (!full || pop);
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prt_port_regs.sv
module prt_port_regs
  import prt_pkg::*;
#(
  parameter int unsigned OUT_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              pin_valid,
  input  logic [BYTE_W-1:0] pin_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  logic [BYTE_W-1:0] dataw_w, datar_w, status_w, ctrl_w, emit_data_w;
  logic              pend_w, emit_w;

  prt_reg_core #(.W(BYTE_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr), .wdata(bus_wdata),
    .pin_valid(pin_valid), .pin_data(pin_data),
    .dataw_q(dataw_w), .datar_q(datar_w), .stat_q(status_w), .ctrl_q(ctrl_w),
    .pend_q(pend_w), .emit(emit_w), .emit_data(emit_data_w)
  );

  prt_rd_mux #(.W(BYTE_W)) rmux_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
    .dataw(dataw_w), .datar(datar_w), .stat(status_w), .ctrl(ctrl_w),
    .rdata_q(bus_rdata)
  );

  prt_byte_fifo #(.W(BYTE_W), .DEPTH(OUT_DEPTH)) ofifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(emit_w), .push_data(emit_data_w),
    .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data)
  );

  assign irq = pend_w;
endmodule

// File: rtl/prt_port_regs_chk.sv
module prt_port_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr_en,
  input logic       bus_rd_en,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       irq,
  input logic [7:0] status_w
);
  p_unmapped_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !bus_wr_en && bus_addr > 3'd2) |=> bus_rdata == 8'hFF)
    else $error("unmapped read not 0xFF");

  p_ctrl_top_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !bus_wr_en && bus_addr == 3'd2) |=> bus_rdata[7:6] == 2'b11)
    else $error("control bits 7:6 not set");

  p_init_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 3'd2 && !bus_wdata[2]) |=> status_w == 8'hD8)
    else $error("init write did not load status");

  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 3'd2 && bus_wdata[2] && bus_wdata[3] && bus_wdata[0])
    |=> !status_w[7])
    else $error("strobe did not clear busy");

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !bus_wr_en && bus_addr == 3'd1) |=> !irq)
    else $error("status read left irq high");

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
    else $error("stalled byte changed");

  p_rd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_wr_en) |=> $stable(bus_rdata))
    else $error("colliding read updated rdata");
endmodule

bind prt_port_regs prt_port_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq),
  .status_w(status_w)
);

// File: tb/prt_port_regs_tb_top.sv
module prt_port_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pin_valid = 1'b0;
  logic [7:0] pin_data = '0;
  logic       tx_valid, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] cap [16];
  int cap_n = 0;

  always #5 clk = ~clk;

  prt_port_regs #(.OUT_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_valid(pin_valid), .pin_data(pin_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
  );

  // stream capture: a transfer happens at the next rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready && cap_n < 16) begin
      cap[cap_n] = tx_data;
      cap_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr_en = 0; bus_rd_en = 0; pin_valid = 0; tx_ready = 1;
    repeat (3) @(negedge clk);
    cap_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd_en = 1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 0;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    do_reset();
    check("R2 irq", int'(irq), 0);
    check("R2 tx_valid", int'(tx_valid), 0);
    rd(3'd2, v); check("R2 control", v, 8'hCC);
    rd(3'd1, v); check("R2 status", v, 8'hD9);
    rd(3'd0, v); check("R2 data", v, 8'hFF);
  endtask

  task automatic t_offsets();
    logic [7:0] v;
    do_reset();
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), v); check("R1 unmapped read", v, 8'hFF);
    end
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h12);
    rd(3'd1, v); check("R1 status write ignored", v, 8'hD9);
    rd(3'd2, v); check("R1 control untouched", v, 8'hCC);
    rd(3'd0, v); check("R1 data untouched", v, 8'hFF);
    repeat (2) @(negedge clk);
    check("R1 rdata holds", bus_rdata, 8'hFF);
  endtask

  task automatic t_ctrl_init();
    logic [7:0] v;
    do_reset();
    wr(3'd2, 8'h05);
    rd(3'd2, v); check("R3 forced top bits", v, 8'hC5);
    rd(3'd1, v); check("R3 no action without select", v, 8'hD9);
    wr(3'd2, 8'h08);
    rd(3'd1, v); check("R4 init low status", v, 8'hD8);
    rd(3'd2, v); check("R3 control readback", v, 8'hC8);
  endtask

  task automatic t_handshake();
    logic [7:0] v;
    do_reset();
    wr(3'd0, 8'h41);
    wr(3'd2, 8'hCD);
    wr(3'd2, 8'hCD);
    repeat (3) @(negedge clk);
    check("R5 single emit count", cap_n, 1);
    check("R5 emitted byte", cap[0], 8'h41);
    rd(3'd1, v); check("R5 busy cleared, strobe held", v, 8'h59);
    rd(3'd1, v); check("R8 no advance while strobe set", v, 8'h59);
    wr(3'd2, 8'hCC);
    rd(3'd1, v); check("R8 poll 1", v, 8'h59);
    rd(3'd1, v); check("R8 ack cleared", v, 8'h19);
    rd(3'd1, v); check("R8 ack and busy set", v, 8'hD9);
    rd(3'd1, v); check("R8 idle stays", v, 8'hD9);
    wr(3'd0, 8'h42);
    wr(3'd2, 8'hCD);
    repeat (3) @(negedge clk);
    check("R5 fresh edge emits", cap_n, 2);
    check("R11 order", cap[1], 8'h42);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    do_reset();
    wr(3'd2, 8'hDC);
    check("R6 enable not yet stored", int'(irq), 0);
    wr(3'd2, 8'hDC);
    check("R6 pending raised", int'(irq), 1);
    wr(3'd0, 8'h00);
    check("R6 irq held", int'(irq), 1);
    rd(3'd1, v);
    check("R7 status value", v, 8'hD9);
    check("R7 irq cleared", int'(irq), 0);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    do_reset();
    @(negedge clk); pin_valid = 1; pin_data = 8'h5A;
    @(negedge clk); pin_valid = 0; pin_data = 8'h00;
    wr(3'd0, 8'h33);
    rd(3'd0, v); check("R9 output direction", v, 8'h33);
    wr(3'd2, 8'hEC);
    rd(3'd0, v); check("R10 input byte via R9", v, 8'h5A);
  endtask

  task automatic t_backpressure();
    do_reset();
    @(negedge clk); tx_ready = 0;
    for (int i = 1; i <= 3; i++) begin
      wr(3'd0, 8'(8'hA0 + i));
      wr(3'd2, 8'hCC);
      wr(3'd2, 8'hCD);
    end
    check("R11 valid while stalled", int'(tx_valid), 1);
    check("R11 head held", tx_data, 8'hA1);
    @(negedge clk); tx_ready = 1;
    repeat (5) @(negedge clk);
    check("R11 drop when full", cap_n, 2);
    check("R11 first", cap[0], 8'hA1);
    check("R11 second", cap[1], 8'hA2);
    check("R11 drained", int'(tx_valid), 0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    do_reset();
    rd(3'd2, v); check("R12 setup", v, 8'hCC);
    @(negedge clk);
    bus_rd_en = 1; bus_wr_en = 1; bus_addr = 3'd0; bus_wdata = 8'h77;
    @(negedge clk);
    bus_rd_en = 0; bus_wr_en = 0;
    check("R12 read ignored", bus_rdata, 8'hCC);
    rd(3'd0, v); check("R12 write taken", v, 8'h77);
  endtask

  initial begin
    t_reset_state();
    t_offsets();
    t_ctrl_init();
    t_handshake();
    t_irq();
    t_direction();
    t_backpressure();
    t_collision();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule